// File: doc/BRIEF.md
# Vectorised Conditional Branch Evaluator

This block works out one element step of a conditional branch that runs inside a vector loop. For each step it receives these inputs:

- the branch option field and a condition-register bit selector;
- a 14-bit word displacement;
- the addressing and link flags;
- the 32-bit condition register and the current instruction address;
- the address-width mode;
- the loop controls, and the index of the current element step.

All decisions are combinational. They are whether the branch is taken, the next instruction address, whether the loop ends, and the proposed new values of the count register, the link register and the loop-length field.

The block holds three registers: the 64-bit count register, the 64-bit link register and a 7-bit loop-length field. These are committed on the clock edge at which `valid` is high. A separate load strobe writes the count and link registers directly, as a move-to-register operation would. The loop controls add four behaviours to the plain scalar branch test. Zeroing mode can force the test bit. The loop can be cut short on a chosen condition outcome. An all-elements mode branches only once the loop has finished, and leaves early when an element fails. The link register can be written even when no branch is taken.

Top module: `bcv_branch_unit`

## Requirements
- R1: When `zero_mode` is 1 the test bit is `zero_bit`. Otherwise it is `cr[31 - cr_sel]`, so selector 0 picks the most significant condition bit.
- R2: The condition passes when `bopt[3]` (skip condition) is 1, or when the test bit equals `bopt[2]` (wanted value).
- R3: `ctr_next` is `ctr_q - 1` when `bopt[1]` (keep count) is 0, and `ctr_q` otherwise. The count test passes when `bopt[1]` is 1, or when (`ctr_next` is nonzero) XOR `bopt[0]` is 1. "Nonzero" looks at all 64 bits when `mode64` is 1 and at bits 31:0 otherwise.
- R4: When `trunc_en` is 1 and the condition result equals `trunc_sense`, three outputs follow: `step_we` is 1, `step_next` is `cur_step + 1` (modulo 128) and `end_loop` is 1. When this does not happen, `step_we` is 0.
- R5: With `all_mode` at 0, `taken` is 1 exactly when both the count test and the condition pass. Whenever `taken` is 1, `end_loop` is also 1.
- R6: With `all_mode` at 1, a branch is attempted only if R4 has already set `end_loop`. A failed condition sets `end_loop` and forces `taken` to 0.
- R7: The branch offset is `{disp, 2'b00}` sign-extended to 64 bits. The target is the offset itself when `abs_mode` is 1, and `cia` plus the offset otherwise. `nia` is the target when taken, and `cia + 4` otherwise.
- R8: `link_we` is `link_en & (taken | link_always)`. `link_next` is `cia + 4`.
- R9: When `mode64` is 0, bits 63:32 of `nia` and `link_next` are 0.
- R10: `ld_en` loads `ld_ctr` into `ctr_q` and `ld_link` into `link_q`, and `valid` is ignored in that cycle. Otherwise, on an edge with `valid` at 1, three updates happen: `ctr_q` takes `ctr_next`, `link_q` takes `link_next` if `link_we`, and `step_q` takes `step_next` if `step_we`. With neither strobe set, all three registers hold.
- R11: Synchronous active-high `rst` clears `ctr_q`, `link_q` and `step_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Direct load of count and link registers |
| ld_ctr | input | 64 | Count value to load |
| ld_link | input | 64 | Link value to load |
| valid | input | 1 | Commit this element step on the edge |
| bopt | input | 4 | Branch options: [3] skip cond, [2] wanted bit, [1] keep count, [0] zero sense |
| cr_sel | input | 5 | Condition bit selector, MSB-first |
| disp | input | 14 | Word displacement |
| abs_mode | input | 1 | Absolute target |
| link_en | input | 1 | Link-write request |
| cr | input | 32 | Condition register |
| cia | input | 64 | Current instruction address |
| mode64 | input | 1 | 1: 64-bit addressing, 0: 32-bit |
| zero_mode | input | 1 | Force test bit from `zero_bit` |
| zero_bit | input | 1 | Forced test bit value |
| trunc_en | input | 1 | Enable loop-length truncation |
| trunc_sense | input | 1 | Condition result that truncates |
| all_mode | input | 1 | Branch only after all elements |
| link_always | input | 1 | Write link even if not taken |
| cur_step | input | 7 | Current element step index |
| taken | output | 1 | Branch taken |
| nia | output | 64 | Next instruction address |
| end_loop | output | 1 | Loop ends after this step |
| ctr_next | output | 64 | Proposed count value |
| link_next | output | 64 | Proposed link value |
| link_we | output | 1 | Link register will be written |
| step_next | output | 7 | Proposed loop-length value |
| step_we | output | 1 | Loop-length field will be written |
| ctr_q | output | 64 | Count register |
| link_q | output | 64 | Link register |
| step_q | output | 7 | Loop-length register |

## Verification
The assertions watch, on every cycle, the relations that hold whatever the operands are:

- register commit, hold and reset;
- the keep-count bit leaving the count unchanged;
- a taken branch always ending the loop;
- all-elements mode never branching without a prior truncation;
- the link write needing its request;
- zero upper halves in 32-bit mode;
- the fall-through address.

The actual outcome depends on the selected condition bit and the forced test bit. It also depends on the 32-bit versus 64-bit zero test of the decremented count, the sign-extended target arithmetic and the wrap of the step index. All of these are shown only by the bench's sweep. The sweep covers every option field and loop-control pairing against a model computed in the bench.

// File: rtl/bcv_pkg.sv
package bcv_pkg;

    localparam int ADDR_W = 64;
    localparam int CR_W   = 32;
    localparam int DISP_W = 14;
    localparam int STEP_W = 7;
    localparam int OPT_W  = 4;
    localparam int SEL_W  = $clog2(CR_W);
    localparam int HALF_W = ADDR_W / 2;

    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    // option field, most significant bit first
    typedef struct packed {
        logic skip_cond;
        logic want_bit;
        logic keep_count;
        logic zero_sense;
    } bopt_t;

    typedef struct packed {
        logic taken;
        logic end_loop;
        logic step_we;
    } loop_res_t;

    typedef struct packed {
        logic [ADDR_W-1:0] nia;
        logic [ADDR_W-1:0] link_val;
        logic              link_we;
    } addr_res_t;

    function automatic logic [ADDR_W-1:0] mode_mask(input logic [ADDR_W-1:0] a,
                                                    input logic wide);
        return wide ? a : {{HALF_W{1'b0}}, a[HALF_W-1:0]};
    endfunction

    function automatic logic [ADDR_W-1:0] disp_offset(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W-2){d[DISP_W-1]}}, d, 2'b00};
    endfunction

endpackage

// File: rtl/bcv_cond_eval.sv
module bcv_cond_eval
    import bcv_pkg::*;
#(
    parameter int CRW = CR_W,
    parameter int SW  = $clog2(CRW)
) (
    input  logic [CRW-1:0] cr,
    input  logic [SW-1:0]  cr_sel,
    input  logic           zero_mode,
    input  logic           zero_bit,
    input  logic           skip_cond,
    input  logic           want_bit,
    output logic           test_bit,
    output logic           cond_ok
);

    // condition bits renumbered so index 0 is the most significant bit
    logic [CRW-1:0] cr_msb_first;

    genvar gi;
    generate
        for (gi = 0; gi < CRW; gi++) begin : g_rev
            assign cr_msb_first[gi] = cr[CRW-1-gi];
        end
    endgenerate

    always_comb begin
        test_bit = zero_mode ? zero_bit : cr_msb_first[cr_sel];
        cond_ok  = skip_cond | ~(test_bit ^ want_bit);
    end

endmodule

// File: rtl/bcv_count_eval.sv
module bcv_count_eval
    import bcv_pkg::*;
#(
    parameter int W = ADDR_W
) (
    input  logic [W-1:0] ctr_q,
    input  logic         keep_count,
    input  logic         zero_sense,
    input  logic         wide,
    output logic [W-1:0] ctr_next,
    output logic         ctr_ok
);

    localparam int HW = W / 2;

    logic nz_lo;
    logic nz_hi;
    logic nz;

    always_comb begin
        ctr_next = keep_count ? ctr_q : ctr_q - W'(1);
        nz_lo    = |ctr_next[HW-1:0];
        nz_hi    = |ctr_next[W-1:HW];
        // narrow mode ignores the upper half of the count
        nz       = nz_lo | (wide & nz_hi);
        ctr_ok   = keep_count | (nz ^ zero_sense);
    end

endmodule

// File: rtl/bcv_loop_ctl.sv
module bcv_loop_ctl
    import bcv_pkg::*;
#(
    parameter int SW = STEP_W
) (
    input  logic          cond_ok,
    input  logic          ctr_ok,
    input  logic          trunc_en,
    input  logic          trunc_sense,
    input  logic          all_mode,
    input  logic [SW-1:0] cur_step,
    output logic [SW-1:0] step_next,
    output loop_res_t     res
);

    logic trunc_hit;
    logic attempt;

    always_comb begin
        trunc_hit = trunc_en & (cond_ok == trunc_sense);
        step_next = cur_step + SW'(1);
        res.step_we  = trunc_hit;
        res.end_loop = trunc_hit;
        attempt      = 1'b1;
        if (all_mode) begin
            if (!trunc_hit) attempt = 1'b0;
            if (!cond_ok) begin
                res.end_loop = 1'b1;
                attempt      = 1'b0;
            end
        end
        res.taken = attempt & ctr_ok & cond_ok;
        if (res.taken) res.end_loop = 1'b1;
    end

endmodule

// File: rtl/bcv_addr_gen.sv
module bcv_addr_gen
    import bcv_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DISP_W
) (
    input  logic [AW-1:0] cia,
    input  logic [DW-1:0] disp,
    input  logic          abs_mode,
    input  logic          wide,
    input  logic          taken,
    input  logic          link_en,
    input  logic          link_always,
    output addr_res_t     res
);

    logic [AW-1:0] offset;
    logic [AW-1:0] target;
    logic [AW-1:0] seq_addr;

    always_comb begin
        offset   = disp_offset(disp);
        target   = mode_mask(abs_mode ? offset : cia + offset, wide);
        seq_addr = mode_mask(cia + INSN_BYTES, wide);
        res.nia      = taken ? target : seq_addr;
        res.link_val = seq_addr;
        res.link_we  = link_en & (taken | link_always);
    end

endmodule

// File: rtl/bcv_branch_unit.sv
module bcv_branch_unit
    import bcv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_ctr,
    input  logic [ADDR_W-1:0] ld_link,
    input  logic              valid,
    input  logic [OPT_W-1:0]  bopt,
    input  logic [SEL_W-1:0]  cr_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic              abs_mode,
    input  logic              link_en,
    input  logic [CR_W-1:0]   cr,
    input  logic [ADDR_W-1:0] cia,
    input  logic              mode64,
    input  logic              zero_mode,
    input  logic              zero_bit,
    input  logic              trunc_en,
    input  logic              trunc_sense,
    input  logic              all_mode,
    input  logic              link_always,
    input  logic [STEP_W-1:0] cur_step,
    output logic              taken,
    output logic [ADDR_W-1:0] nia,
    output logic              end_loop,
    output logic [ADDR_W-1:0] ctr_next,
    output logic [ADDR_W-1:0] link_next,
    output logic              link_we,
    output logic [STEP_W-1:0] step_next,
    output logic              step_we,
    output logic [ADDR_W-1:0] ctr_q,
    output logic [ADDR_W-1:0] link_q,
    output logic [STEP_W-1:0] step_q
);

    bopt_t     opt;
    logic      test_bit;
    logic      cond_ok;
    logic      ctr_ok;
    loop_res_t loop_res;
    addr_res_t addr_res;

    assign opt = bopt_t'(bopt);

    bcv_cond_eval #(.CRW(CR_W), .SW(SEL_W)) u_cond (
        .cr        (cr),
        .cr_sel    (cr_sel),
        .zero_mode (zero_mode),
        .zero_bit  (zero_bit),
        .skip_cond (opt.skip_cond),
        .want_bit  (opt.want_bit),
        .test_bit  (test_bit),
        .cond_ok   (cond_ok)
    );

    bcv_count_eval #(.W(ADDR_W)) u_count (
        .ctr_q      (ctr_q),
        .keep_count (opt.keep_count),
        .zero_sense (opt.zero_sense),
        .wide       (mode64),
        .ctr_next   (ctr_next),
        .ctr_ok     (ctr_ok)
    );

    bcv_loop_ctl #(.SW(STEP_W)) u_loop (
        .cond_ok     (cond_ok),
        .ctr_ok      (ctr_ok),
        .trunc_en    (trunc_en),
        .trunc_sense (trunc_sense),
        .all_mode    (all_mode),
        .cur_step    (cur_step),
        .step_next   (step_next),
        .res         (loop_res)
    );

    bcv_addr_gen #(.AW(ADDR_W), .DW(DISP_W)) u_addr (
        .cia         (cia),
        .disp        (disp),
        .abs_mode    (abs_mode),
        .wide        (mode64),
        .taken       (loop_res.taken),
        .link_en     (link_en),
        .link_always (link_always),
        .res         (addr_res)
    );

    always_comb begin
        taken     = loop_res.taken;
        end_loop  = loop_res.end_loop;
        step_we   = loop_res.step_we;
        nia       = addr_res.nia;
        link_next = addr_res.link_val;
        link_we   = addr_res.link_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q  <= '0;
            link_q <= '0;
            step_q <= '0;
        end else if (ld_en) begin
            ctr_q  <= ld_ctr;
            link_q <= ld_link;
        end else if (valid) begin
            ctr_q <= ctr_next;
            if (link_we) link_q <= link_next;
            if (step_we) step_q <= step_next;
        end
    end

endmodule

// File: rtl/bcv_branch_chk.sv
module bcv_branch_chk
    import bcv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ld_en,
    input logic              valid,
    input logic [OPT_W-1:0]  bopt,
    input logic              link_en,
    input logic [ADDR_W-1:0] cia,
    input logic              mode64,
    input logic              trunc_en,
    input logic              all_mode,
    input logic [STEP_W-1:0] cur_step,
    input logic              taken,
    input logic [ADDR_W-1:0] nia,
    input logic              end_loop,
    input logic [ADDR_W-1:0] ctr_next,
    input logic [ADDR_W-1:0] link_next,
    input logic              link_we,
    input logic              step_we,
    input logic [ADDR_W-1:0] ctr_q,
    input logic [ADDR_W-1:0] link_q,
    input logic [STEP_W-1:0] step_q
);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctr_q == '0 && link_q == '0 && step_q == '0));

    // R10
    ctr_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ld_en) |=> ctr_q == $past(ctr_next));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid && !ld_en) |=> ($stable(ctr_q) && $stable(link_q) && $stable(step_q)));

    // R4
    step_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ld_en && step_we) |=> step_q == $past(cur_step) + STEP_W'(1));

    // R3
    count_keep_chk: assert property (@(posedge clk) disable iff (rst)
        bopt[1] |-> ctr_next == ctr_q);

    // R3
    count_dec_chk: assert property (@(posedge clk) disable iff (rst)
        !bopt[1] |-> ctr_next == ctr_q - ADDR_W'(1));

    // R5
    taken_ends_chk: assert property (@(posedge clk) disable iff (rst)
        taken |-> end_loop);

    // R6
    all_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (all_mode && !trunc_en) |-> !taken);

    // R8
    link_gate_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |-> link_en);

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !mode64 |-> (nia[ADDR_W-1:HALF_W] == '0 && link_next[ADDR_W-1:HALF_W] == '0));

    // R7
    fall_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (!taken && mode64) |-> nia == cia + ADDR_W'(4));

endmodule

bind bcv_branch_unit bcv_branch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_en),
    .valid     (valid),
    .bopt      (bopt),
    .link_en   (link_en),
    .cia       (cia),
    .mode64    (mode64),
    .trunc_en  (trunc_en),
    .all_mode  (all_mode),
    .cur_step  (cur_step),
    .taken     (taken),
    .nia       (nia),
    .end_loop  (end_loop),
    .ctr_next  (ctr_next),
    .link_next (link_next),
    .link_we   (link_we),
    .step_we   (step_we),
    .ctr_q     (ctr_q),
    .link_q    (link_q),
    .step_q    (step_q)
);

// File: tb/bcv_branch_unit_tb.sv
module bcv_branch_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [63:0] ld_ctr;
    logic [63:0] ld_link;
    logic        valid;
    logic [3:0]  bopt;
    logic [4:0]  cr_sel;
    logic [13:0] disp;
    logic        abs_mode;
    logic        link_en;
    logic [31:0] cr;
    logic [63:0] cia;
    logic        mode64;
    logic        zero_mode;
    logic        zero_bit;
    logic        trunc_en;
    logic        trunc_sense;
    logic        all_mode;
    logic        link_always;
    logic [6:0]  cur_step;
    logic        taken;
    logic [63:0] nia;
    logic        end_loop;
    logic [63:0] ctr_next;
    logic [63:0] link_next;
    logic        link_we;
    logic [6:0]  step_next;
    logic        step_we;
    logic [63:0] ctr_q;
    logic [63:0] link_q;
    logic [6:0]  step_q;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bcv_branch_unit u_dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_ctr(ld_ctr), .ld_link(ld_link),
        .valid(valid), .bopt(bopt), .cr_sel(cr_sel), .disp(disp),
        .abs_mode(abs_mode), .link_en(link_en), .cr(cr), .cia(cia),
        .mode64(mode64), .zero_mode(zero_mode), .zero_bit(zero_bit),
        .trunc_en(trunc_en), .trunc_sense(trunc_sense), .all_mode(all_mode),
        .link_always(link_always), .cur_step(cur_step), .taken(taken),
        .nia(nia), .end_loop(end_loop), .ctr_next(ctr_next),
        .link_next(link_next), .link_we(link_we), .step_next(step_next),
        .step_we(step_we), .ctr_q(ctr_q), .link_q(link_q), .step_q(step_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] narrow(input logic [63:0] a, input logic w);
        return w ? a : (a & 64'h0000_0000_FFFF_FFFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [6:0]  exp_step;
        logic [63:0] exp_link;
        rst = 1'b1; ld_en = 1'b0; ld_ctr = '0; ld_link = '0; valid = 1'b0;
        bopt = '0; cr_sel = '0; disp = '0; abs_mode = 1'b0; link_en = 1'b0;
        cr = '0; cia = '0; mode64 = 1'b1; zero_mode = 1'b0; zero_bit = 1'b0;
        trunc_en = 1'b0; trunc_sense = 1'b0; all_mode = 1'b0; link_always = 1'b0;
        cur_step = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 ctr_q after reset", ctr_q, 64'd0);
        chk("R11 link_q after reset", link_q, 64'd0);
        chk("R11 step_q after reset", {57'd0, step_q}, 64'd0);
        exp_step = '0;

        // R10 idle cycles leave registers alone
        ld_en = 1'b1; ld_ctr = 64'h55; ld_link = 64'h77;
        @(posedge clk); @(negedge clk);
        ld_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 ctr_q after load and idle", ctr_q, 64'h55);
        chk("R10 link_q after load and idle", link_q, 64'h77);

        for (int b = 0; b < 16; b++) begin
            for (int f = 0; f < 64; f++) begin
                for (int m = 0; m < 8; m++) begin
                    int          idx;
                    int          sel;
                    logic [63:0] cval;
                    logic [63:0] lval;
                    logic        tb_bit, cond, nz, cok, hit, attempt, el, tk, lwe;
                    logic [63:0] cnew, off, tgt, ft, nia_e;
                    idx  = b * 512 + f * 8 + m;
                    sel  = (b * 7 + f * 3 + m) % 32;
                    case ((idx / 2) % 5)
                        0: cval = 64'd1;
                        1: cval = 64'd2;
                        2: cval = 64'd0;
                        3: cval = 64'h0000_0001_0000_0001;
                        default: cval = 64'h0000_0001_0000_0000;
                    endcase
                    lval = 64'hC0DE_0000_0000_0000 ^ 64'(idx);

                    // load count and link
                    ld_en = 1'b1; ld_ctr = cval; ld_link = lval; valid = 1'b0;
                    @(posedge clk); @(negedge clk);
                    ld_en = 1'b0;

                    bopt        = 4'(b);
                    zero_mode   = f[0];
                    zero_bit    = f[1];
                    trunc_en    = f[2];
                    trunc_sense = f[3];
                    all_mode    = f[4];
                    link_always = f[5];
                    mode64      = m[0];
                    link_en     = m[1];
                    abs_mode    = m[2];
                    cr_sel      = 5'(sel);
                    cr          = 32'h9A3C_65F1 ^ 32'(idx * 40503);
                    disp        = 14'((idx * 613) ^ (idx >> 3));
                    cur_step    = 7'(idx * 5);
                    case (idx % 3)
                        0: cia = 64'h0000_0000_0000_1000;
                        1: cia = 64'hFFFF_FFFF_FFFF_FFFC;
                        default: cia = 64'h1234_5678_8000_0040;
                    endcase
                    valid = 1'b1;

                    // independent model of the step
                    tb_bit = zero_mode ? zero_bit : cr[31 - sel];
                    cond   = bopt[3] | (tb_bit == bopt[2]);
                    cnew   = bopt[1] ? cval : cval - 64'd1;
                    nz     = mode64 ? (cnew != 64'd0) : (cnew[31:0] != 32'd0);
                    cok    = bopt[1] | (nz ^ bopt[0]);
                    hit    = trunc_en & (cond == trunc_sense);
                    el     = hit;
                    attempt = 1'b1;
                    if (all_mode) begin
                        if (!el) attempt = 1'b0;
                        if (!cond) begin el = 1'b1; attempt = 1'b0; end
                    end
                    tk = attempt & cok & cond;
                    if (tk) el = 1'b1;
                    off   = {{48{disp[13]}}, disp, 2'b00};
                    tgt   = narrow(abs_mode ? off : cia + off, mode64);
                    ft    = narrow(cia + 64'd4, mode64);
                    nia_e = tk ? tgt : ft;
                    lwe   = link_en & (tk | link_always);

                    #1;
                    chk(zero_mode ? "R1 taken (forced test bit)" : "R2 taken (condition bit)",
                        {63'd0, taken}, {63'd0, tk});
                    chk(all_mode ? "R6 end_loop" : "R5 end_loop", {63'd0, end_loop}, {63'd0, el});
                    chk("R3 ctr_next", ctr_next, cnew);
                    chk("R4 step_we", {63'd0, step_we}, {63'd0, hit});
                    if (hit) chk("R4 step_next", {57'd0, step_next}, {57'd0, cur_step + 7'd1});
                    chk(mode64 ? "R7 nia" : "R9 nia (32-bit)", nia, nia_e);
                    chk("R8 link_we", {63'd0, link_we}, {63'd0, lwe});
                    chk(mode64 ? "R8 link_next" : "R9 link_next (32-bit)", link_next, ft);

                    @(posedge clk); @(negedge clk);
                    valid = 1'b0;
                    if (hit) exp_step = cur_step + 7'd1;
                    exp_link = lwe ? ft : lval;
                    chk("R10 ctr_q commit", ctr_q, cnew);
                    chk("R10 link_q commit", link_q, exp_link);
                    chk("R10 step_q commit", {57'd0, step_q}, {57'd0, exp_step});
                end
            end
        end

        // R10 load has priority over valid
        ld_en = 1'b1; ld_ctr = 64'h1234; ld_link = 64'h5678; valid = 1'b1;
        bopt = 4'b0000; trunc_en = 1'b1; trunc_sense = 1'b1; cur_step = 7'd9;
        zero_mode = 1'b1; zero_bit = 1'b1; all_mode = 1'b0;
        @(posedge clk); @(negedge clk);
        ld_en = 1'b0; valid = 1'b0;
        chk("R10 load wins ctr_q", ctr_q, 64'h1234);
        chk("R10 load wins link_q", link_q, 64'h5678);
        chk("R10 load wins step_q", {57'd0, step_q}, {57'd0, exp_step});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule